// File: doc/BRIEF.md
# I2C Slave Address Recognizer

This block sits on the two open-drain lines of an I2C bus. A fast system clock samples them and decides whether the local device is the target of the current transfer. It synchronizes the sampled clock and data lines and finds the START, repeated START and STOP conditions. It shifts in the address bytes, compares them with two software-loaded address registers, and answers a match by pulling the data line low for the acknowledge bit. It never drives the line high. It only asserts a pull-low enable that an external open-drain pad turns into a low level.

The content of the high address register alone selects the addressing mode. A value of zero gives 7-bit addressing against the low register. A value whose upper five bits are 11110 gives 10-bit addressing. In that mode the two bits below those five are the top of the address, the low register holds the remaining eight bits, and the least significant bit is ignored. In 10-bit mode a write selection takes a header byte and a second address byte. A read selection then takes only a repeated START and a read header. After a match the block raises a select flag and a direction flag, and holds both until the next START or STOP. The data phase that follows is handled elsewhere.

Top module: `i2c_addr_matcher`

## Requirements
- R1: START (data falls while clock is high) and STOP (data rises while clock is high) are detected on the synchronized line samples; `busy` goes high after a START and low after a STOP, and is 0 after reset.
- R2: With the high register equal to 8'h00, the first byte after a START matches when its bits 7:1 equal low-register bits 6:0; byte bit 0 is the direction, 1 meaning read, 0 meaning write.
- R3: With high-register bits 7:3 equal to 5'b11110, 10-bit mode applies: a header byte is 5'b11110, then high-register bits 2:1, then the direction bit; high-register bit 0 has no effect; in this mode a 7-bit-style address byte is never acknowledged, and any high-register value that is neither 8'h00 nor 11110xxx matches nothing.
- R4: On a match, `sdaPullLow` rises while SCL is low after the eighth data bit and falls after the falling edge of the ninth (acknowledge) clock pulse; it is the only way the block affects SDA.
- R5: In 10-bit mode, a write header is acknowledged without raising `selected`; a following byte equal to the whole low register is acknowledged and selects the device with `readDir` = 0.
- R6: A 10-bit read header is acknowledged and selects the device with `readDir` = 1 only when a 10-bit write selection was made earlier in the same transfer (no STOP between); otherwise it is not acknowledged.
- R7: A mismatch on any address byte leaves `sdaPullLow` at 0, and later bytes of the same transfer are not acknowledged, even if they equal the address, until a new START.
- R8: `selected` and `readDir` hold their values from the acknowledge until the next START or STOP, both of which clear `selected`; after the selection, data bytes are not acknowledged.
- R9: Recognition works both at a 100 kHz and at a 400 kHz bus rate with the system clock at 100 MHz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Sampled level of the bus clock line |
| sdaIn | input | 1 | Sampled level of the bus data line |
| hiAddr | input | 8 | High slave-address register (mode and top 10-bit address bits) |
| loAddr | input | 8 | Low slave-address register |
| sdaPullLow | output | 1 | When 1, the pad pulls SDA low; when 0, SDA is released |
| selected | output | 1 | Device is addressed in the current transfer |
| readDir | output | 1 | Direction of the selection, 1 = read |
| busy | output | 1 | A START has been seen and no STOP since |

## Verification
The bench goes after the paths that separate the 10-bit handshake from a plain match. It checks that a write header alone does not select. It checks that a wrong low byte stays unacknowledged, that a read header with no prior write selection, or after a STOP, is refused, and that a correct repeated-START read is accepted. A design that ignored the mode field would acknowledge 7-bit-style bytes in 10-bit mode, or match anything when the high register holds an unused pattern. A design that treated the ignored header bit as significant would drop a selection when that bit changes. Further checks confirm the following. A mismatched byte keeps the device deaf to a later correct byte. A repeated START clears the selection at once. The pull is released after the acknowledge clock and is not repeated for data bytes. Recognition is also exercised at the slower standard-mode bus rate.

// File: rtl/i2c_match_pkg.sv
package i2c_match_pkg;

  // Fixed by the bus: address and data move as 8-bit units plus one acknowledge.
  localparam int ADDR_W   = 8;
  localparam int CNT_W    = $clog2(ADDR_W + 2);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(ADDR_W);
  localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(ADDR_W + 1);

  // 10-bit header prefix and the mask that selects it in the high register.
  localparam logic [4:0]        TEN_PREFIX = 5'b11110;
  localparam logic [ADDR_W-1:0] TEN_MASK   = 8'hF8;
  localparam logic [ADDR_W-1:0] TEN_MARK   = 8'hF0;

  // Line events reported by the datapath.
  typedef struct packed {
    logic startEv;
    logic stopEv;
    logic byteDone;
    logic ackEnd;
  } busEvt_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic ackGo;
  } ctlCmd_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_LOW,
    ST_SEL,
    ST_SKIP
  } matchState_t;

endpackage

// File: rtl/i2c_match_dp.sv
module i2c_match_dp
  import i2c_match_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  ctlCmd_t           cmd,
  output busEvt_t           evt,
  output logic [ADDR_W-1:0] rxByte,
  output logic              sdaPullLow
);

  logic [SYNC_STAGES-1:0] sclSync;
  logic [SYNC_STAGES-1:0] sdaSync;
  logic                   sclPrev;
  logic                   sdaPrev;
  logic                   sclNow;
  logic                   sdaNow;
  logic                   sclRise;
  logic                   sclFall;
  logic [CNT_W-1:0]       bitCnt;

  // Synchronizer chains, idle-high after reset.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclNow;
      sdaPrev <= sdaNow;
    end
  end

  assign sclNow  = sclSync[SYNC_STAGES-1];
  assign sdaNow  = sdaSync[SYNC_STAGES-1];
  assign sclRise = sclNow & ~sclPrev;
  assign sclFall = ~sclNow & sclPrev;

  assign evt.startEv  = sclNow & sclPrev & sdaPrev & ~sdaNow;
  assign evt.stopEv   = sclNow & sclPrev & ~sdaPrev & sdaNow;
  assign evt.byteDone = sclFall && (bitCnt == LAST_BIT);
  assign evt.ackEnd   = sclFall && (bitCnt == ACK_SLOT);

  // Bit counter: 0..7 data bits, LAST_BIT after the eighth, ACK_SLOT in the ninth pulse.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
      rxByte <= '0;
    end else if (evt.startEv || evt.stopEv) begin
      bitCnt <= '0;
    end else if (sclRise) begin
      if (bitCnt < LAST_BIT) begin
        rxByte <= {rxByte[ADDR_W-2:0], sdaNow};
        bitCnt <= bitCnt + 1'b1;
      end else if (bitCnt == LAST_BIT) begin
        bitCnt <= ACK_SLOT;
      end
    end else if (evt.ackEnd) begin
      bitCnt <= '0;
    end
  end

  // Acknowledge pull: set by control while SCL is low, cleared after the ninth pulse.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sdaPullLow <= 1'b0;
    end else if (evt.startEv || evt.stopEv || evt.ackEnd) begin
      sdaPullLow <= 1'b0;
    end else if (cmd.ackGo) begin
      sdaPullLow <= 1'b1;
    end
  end

endmodule

// File: rtl/i2c_match_ctl.sv
module i2c_match_ctl
  import i2c_match_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  busEvt_t           evt,
  input  logic [ADDR_W-1:0] rxByte,
  input  logic [ADDR_W-1:0] hiAddr,
  input  logic [ADDR_W-1:0] loAddr,
  output ctlCmd_t           cmd,
  output logic              selected,
  output logic              readDir,
  output logic              busy
);

  matchState_t state;
  matchState_t stNext;
  logic        armed;
  logic        armNext;
  logic        ackNow;
  logic        selSet;
  logic        dirSet;
  logic        sevenMode;
  logic        tenMode;
  logic        sevenHit;
  logic        hdrHit;
  logic [6:0]  hdrTag;

  // Mode comes from the high register only.
  assign sevenMode = (hiAddr == '0);
  assign tenMode   = ((hiAddr & TEN_MASK) == TEN_MARK);
  assign hdrTag    = {TEN_PREFIX, hiAddr[2:1]};
  assign sevenHit  = sevenMode && (rxByte[7:1] == loAddr[6:0]);
  assign hdrHit    = tenMode && (rxByte[7:1] == hdrTag);

  always_comb begin
    ackNow  = 1'b0;
    selSet  = 1'b0;
    dirSet  = 1'b0;
    armNext = armed;
    stNext  = state;
    if (evt.byteDone) begin
      unique case (state)
        ST_HDR: begin
          armNext = 1'b0;
          stNext  = ST_SKIP;
          if (sevenHit) begin
            ackNow = 1'b1;
            selSet = 1'b1;
            dirSet = rxByte[0];
            stNext = ST_SEL;
          end else if (hdrHit && !rxByte[0]) begin
            ackNow = 1'b1;
            stNext = ST_LOW;
          end else if (hdrHit && armed) begin
            ackNow  = 1'b1;
            selSet  = 1'b1;
            dirSet  = 1'b1;
            armNext = 1'b1;
            stNext  = ST_SEL;
          end
        end
        ST_LOW: begin
          if (tenMode && (rxByte == loAddr)) begin
            ackNow  = 1'b1;
            selSet  = 1'b1;
            armNext = 1'b1;
            stNext  = ST_SEL;
          end else begin
            stNext = ST_SKIP;
          end
        end
        default: ;
      endcase
    end
  end

  assign cmd.ackGo = ackNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      armed    <= 1'b0;
      selected <= 1'b0;
      readDir  <= 1'b0;
      busy     <= 1'b0;
    end else if (evt.startEv) begin
      state    <= ST_HDR;
      selected <= 1'b0;
      readDir  <= 1'b0;
      busy     <= 1'b1;
    end else if (evt.stopEv) begin
      state    <= ST_IDLE;
      armed    <= 1'b0;
      selected <= 1'b0;
      readDir  <= 1'b0;
      busy     <= 1'b0;
    end else begin
      state <= stNext;
      armed <= armNext;
      if (selSet) begin
        selected <= 1'b1;
        readDir  <= dirSet;
      end
    end
  end

endmodule

// File: rtl/i2c_addr_matcher.sv
module i2c_addr_matcher
  import i2c_match_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [7:0] hiAddr,
  input  logic [7:0] loAddr,
  output logic       sdaPullLow,
  output logic       selected,
  output logic       readDir,
  output logic       busy
);

  busEvt_t           evt;
  ctlCmd_t           cmd;
  logic [ADDR_W-1:0] rxByte;
  logic              startSeen;
  logic              stopSeen;

  i2c_match_dp #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .sclIn      (sclIn),
    .sdaIn      (sdaIn),
    .cmd        (cmd),
    .evt        (evt),
    .rxByte     (rxByte),
    .sdaPullLow (sdaPullLow)
  );

  i2c_match_ctl u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .evt      (evt),
    .rxByte   (rxByte),
    .hiAddr   (hiAddr),
    .loAddr   (loAddr),
    .cmd      (cmd),
    .selected (selected),
    .readDir  (readDir),
    .busy     (busy)
  );

  assign startSeen = evt.startEv;
  assign stopSeen  = evt.stopEv;

endmodule

// File: rtl/i2c_addr_matcher_chk.sv
module i2c_addr_matcher_chk (
  input logic clk,
  input logic rstN,
  input logic sclIn,
  input logic sdaPullLow,
  input logic selected,
  input logic readDir,
  input logic busy,
  input logic startSeen,
  input logic stopSeen
);

  // R4: the pull only begins while the bus clock is low
  p_pull_rise_scl_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaPullLow) |-> !sclIn);

  // R4: the pull never appears outside a transfer
  p_pull_needs_busy_r4: assert property (@(posedge clk) disable iff (!rstN)
    sdaPullLow |-> busy);

  // R1: a START makes the block busy
  p_busy_after_start_r1: assert property (@(posedge clk) disable iff (!rstN)
    startSeen |=> busy);

  // R1: a STOP returns to idle and drops any selection
  p_idle_after_stop_r1: assert property (@(posedge clk) disable iff (!rstN)
    stopSeen |=> (!busy && !selected && !sdaPullLow));

  // R8: a START clears the selection
  p_start_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    startSeen |=> !selected);

  // R8: selection holds until START or STOP
  p_sel_holds_r8: assert property (@(posedge clk) disable iff (!rstN)
    (selected && !startSeen && !stopSeen) |=> selected);

  // R8: direction is stable while selected
  p_dir_holds_r8: assert property (@(posedge clk) disable iff (!rstN)
    (selected && !startSeen && !stopSeen) |=> $stable(readDir));

  // R8: selection only exists inside a transfer
  p_sel_needs_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    selected |-> busy);

endmodule

bind i2c_addr_matcher i2c_addr_matcher_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .sclIn      (sclIn),
  .sdaPullLow (sdaPullLow),
  .selected   (selected),
  .readDir    (readDir),
  .busy       (busy),
  .startSeen  (startSeen),
  .stopSeen   (stopSeen)
);

// File: tb/i2c_addr_matcher_test.sv
module i2c_addr_matcher_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       mScl = 1'b1;
  logic       mSda = 1'b1;
  logic [7:0] hiAddr = 8'h00;
  logic [7:0] loAddr = 8'h3A;
  logic       sdaPullLow;
  logic       selected;
  logic       readDir;
  logic       busy;
  logic       sdaBus;

  int checks = 0;
  int errors = 0;
  int q = 62;          // quarter bit period in clocks: 62 -> ~400 kHz, 250 -> 100 kHz
  bit done = 1'b0;

  always #5 clk = ~clk;

  assign sdaBus = mSda & ~sdaPullLow;

  i2c_addr_matcher uut (
    .clk        (clk),
    .rstN       (rstN),
    .sclIn      (mScl),
    .sdaIn      (sdaBus),
    .hiAddr     (hiAddr),
    .loAddr     (loAddr),
    .sdaPullLow (sdaPullLow),
    .selected   (selected),
    .readDir    (readDir),
    .busy       (busy)
  );

  task automatic check(input logic cond, input string tag, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic quarter();
    repeat (q) @(negedge clk);
  endtask

  task automatic sendStart();
    mSda = 1'b1; mScl = 1'b1; quarter();
    mSda = 1'b0; quarter();
    mScl = 1'b0; quarter();
  endtask

  task automatic sendRestart();
    mSda = 1'b1; quarter();
    mScl = 1'b1; quarter();
    mSda = 1'b0; quarter();
    mScl = 1'b0; quarter();
  endtask

  task automatic sendStop();
    mSda = 1'b0; quarter();
    mScl = 1'b1; quarter();
    mSda = 1'b1; quarter();
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked,
                          output logic selAck, output logic dirAck);
    for (int i = 7; i >= 0; i--) begin
      mSda = b[i]; quarter();
      mScl = 1'b1; quarter(); quarter();
      mScl = 1'b0;
    end
    mSda = 1'b1; quarter();
    mScl = 1'b1; quarter();
    acked  = ~sdaBus;
    selAck = selected;
    dirAck = readDir;
    quarter();
    mScl = 1'b0; quarter();
  endtask

  task automatic t_reset();
    check(sdaPullLow == 1'b0, "R4 reset pull", sdaPullLow, 0);
    check(selected == 1'b0, "R8 reset selected", selected, 0);
    check(busy == 1'b0, "R1 reset busy", busy, 0);
  endtask

  task automatic t_seven_write();
    logic a, s, d;
    hiAddr = 8'h00; loAddr = 8'h3A;
    sendStart();
    check(busy == 1'b1, "R1 busy after START", busy, 1);
    sendByte({7'h3A, 1'b0}, a, s, d);
    check(a == 1'b1, "R2 7-bit write ack", a, 1);
    check(s == 1'b1, "R2 7-bit selected", s, 1);
    check(d == 1'b0, "R2 7-bit write dir", d, 0);
    check(sdaPullLow == 1'b0, "R4 pull released after ack", sdaPullLow, 0);
    sendStop(); quarter();
    check(selected == 1'b0, "R8 STOP clears selected", selected, 0);
    check(busy == 1'b0, "R1 busy after STOP", busy, 0);
  endtask

  task automatic t_seven_read();
    logic a, s, d;
    sendStart();
    sendByte({7'h3A, 1'b1}, a, s, d);
    check(a == 1'b1, "R2 7-bit read ack", a, 1);
    check(d == 1'b1, "R2 7-bit read dir", d, 1);
    sendByte(8'h00, a, s, d);
    check(a == 1'b0, "R8 data byte not acked", a, 0);
    check(s == 1'b1 && d == 1'b1, "R8 selection held", {s, d}, 3);
    sendStop(); quarter();
  endtask

  task automatic t_seven_miss();
    logic a, s, d;
    sendStart();
    sendByte({7'h3B, 1'b0}, a, s, d);
    check(a == 1'b0, "R7 mismatch no ack", a, 0);
    check(s == 1'b0, "R7 mismatch not selected", s, 0);
    sendByte({7'h3A, 1'b0}, a, s, d);
    check(a == 1'b0, "R7 later match ignored", a, 0);
    sendStop(); quarter();
  endtask

  task automatic t_restart_clears();
    logic a, s, d;
    sendStart();
    sendByte({7'h3A, 1'b0}, a, s, d);
    check(s == 1'b1, "R8 selected before restart", s, 1);
    sendRestart();
    check(selected == 1'b0, "R8 repeated START clears", selected, 0);
    sendByte({7'h3A, 1'b1}, a, s, d);
    check(a == 1'b1 && d == 1'b1, "R2 reselect for read", {a, d}, 3);
    sendStop(); quarter();
  endtask

  task automatic t_ten_write(input logic [7:0] hi, input string tag);
    logic a, s, d;
    hiAddr = hi; loAddr = 8'h5C;
    sendStart();
    sendByte({5'b11110, 2'b10, 1'b0}, a, s, d);
    check(a == 1'b1, {tag, " header ack"}, a, 1);
    check(s == 1'b0, "R5 header alone not selected", s, 0);
    sendByte(8'h5C, a, s, d);
    check(a == 1'b1 && s == 1'b1 && d == 1'b0, {tag, " low byte selects write"}, {a, s, d}, 6);
    sendStop(); quarter();
  endtask

  task automatic t_ten_read();
    logic a, s, d;
    hiAddr = 8'hF4; loAddr = 8'h5C;
    sendStart();
    sendByte(8'hF4, a, s, d);
    sendByte(8'h5C, a, s, d);
    sendRestart();
    sendByte(8'hF5, a, s, d);
    check(a == 1'b1, "R6 read header ack", a, 1);
    check(s == 1'b1 && d == 1'b1, "R6 read selected", {s, d}, 3);
    sendStop(); quarter();
    sendStart();
    sendByte(8'hF5, a, s, d);
    check(a == 1'b0 && s == 1'b0, "R6 read header after STOP refused", {a, s}, 0);
    sendStop(); quarter();
  endtask

  task automatic t_ten_bad();
    logic a, s, d;
    hiAddr = 8'hF4; loAddr = 8'h5C;
    sendStart();
    sendByte(8'hF4, a, s, d);
    sendByte(8'h5D, a, s, d);
    check(a == 1'b0 && s == 1'b0, "R7 wrong low byte", {a, s}, 0);
    sendStop(); quarter();
    sendStart();
    sendByte(8'hF2, a, s, d);
    check(a == 1'b0, "R3 wrong top bits", a, 0);
    sendStop(); quarter();
    sendStart();
    sendByte(8'hB8, a, s, d);
    check(a == 1'b0, "R3 7-bit form refused in 10-bit mode", a, 0);
    sendStop(); quarter();
  endtask

  task automatic t_bad_mode();
    logic a, s, d;
    hiAddr = 8'h55; loAddr = 8'h3A;
    sendStart();
    sendByte({7'h3A, 1'b0}, a, s, d);
    check(a == 1'b0 && s == 1'b0, "R3 unused high pattern matches nothing", {a, s}, 0);
    sendStop(); quarter();
  endtask

  task automatic t_slow();
    logic a, s, d;
    q = 250;
    hiAddr = 8'h00; loAddr = 8'h11;
    sendStart();
    sendByte({7'h11, 1'b0}, a, s, d);
    check(a == 1'b1 && s == 1'b1, "R9 100 kHz 7-bit match", {a, s}, 3);
    sendStop(); quarter();
    q = 62;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_seven_write();
    t_seven_read();
    t_seven_miss();
    t_restart_clears();
    t_ten_write(8'hF4, "R5");
    t_ten_write(8'hF5, "R3 ignored bit");
    t_ten_read();
    t_ten_bad();
    t_bad_mode();
    t_slow();
    finishRun();
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    finishRun();
  end

endmodule